// File: doc/BRIEF.md
# TRNG Register and Alarm Controller

This block is the register front end of a true random number generator. A 32-bit register bus configures the generator, reads finished output blocks and services status. An external entropy source supplies 32-bit words; the controller packs four of them into a block of output words and raises a ready flag. Software reads the words, then writes a 1 to the ready flag to release the next block. An optional minimum refill delay inserts idle cycles before the next block starts filling.

The block also watches the health of the noise oscillators. External test engines report failures as one-cycle pulses, which become sticky status bits. Each oscillator can raise an alarm. The first alarm on an oscillator only marks it. A second alarm on that oscillator switches it off and records it as stopped. When the number of stopped oscillators exceeds a programmed threshold, a shutdown-overflow status bit is set. Status bits are cleared by writing a 1 to them. A single interrupt line combines the status bits with per-bit enables.

Top module: `trng_alarm_ctrl`

## Requirements
- R1: After reset all writable registers, status, `osc_en`, `gen_on` and `irq` read 0.
- R2: Control (0x14) keeps bits 10, 8 and 7:0 only. Config (0x18) keeps bits 31:16 and 7:0. Threshold (0x1C) keeps bits 7:0. Tune (0x24) keeps all 32 bits and drives `osc_tune`. Oscillator enable (0x20), alarm mask (0x28) and alarm stop (0x2C) keep NUM_OSC bits. Options (0x78) reads {NUM_OSC in 15:8, WORDS in 7:0}. Revision (0x7C) reads major, minor and patch in bits 27:24, 23:20 and 19:16.
- R3: With control bit 10 set and ready low, each cycle with `src_valid` stores `src_word` into the next data word (offsets 0x00, 0x04, 0x08, 0x0C, in order). Ready (status bit 0) is set at the edge that stores the fourth word. Source words arriving while ready is set are ignored.
- R4: Writing status with bit 0 set while ready is set clears ready. The next block then ignores `src_valid` for config[7:0] cycles before it accepts words.
- R5: While control bit 10 is 0, ready is forced low, source words are ignored and the data words keep their values.
- R6: Pulse `hlt_fail[k]` sets status bit k+2, and the bit stays set. Writing status clears exactly the bits written as 1. A set and a clear in the same cycle leave the bit set.
- R7: `irq` is the OR over bits 7:0 of (status AND control[7:0]). Control bit 0 enables the ready interrupt.
- R8: An alarm on an enabled oscillator whose alarm-mask bit is 0 sets that mask bit and leaves the oscillator enabled.
- R9: An alarm on an enabled oscillator whose mask bit is 1 clears its enable bit and sets its alarm-stop bit. Alarms on disabled oscillators change nothing.
- R10: When a new stop makes the count of set alarm-stop bits exceed threshold[7:0], status bit 1 is set.
- R11: With control bit 8 set, bus writes to data-word offsets load that word. With bit 8 clear, such writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| src_valid | input | 1 | Entropy word valid |
| src_word | input | 32 | Entropy word |
| hlt_fail | input | 6 | Health-test failure pulses, bit k maps to status bit k+2 |
| alarm_hit | input | NUM_OSC | Per-oscillator alarm pulses |
| osc_en | output | NUM_OSC | Oscillator enables |
| osc_tune | output | 32 | Oscillator detune value |
| gen_on | output | 1 | Generator enable (control bit 10) |
| irq | output | 1 | Interrupt request |

## Verification
The refill delay is checked by feeding a word on every cycle straight after the ready flag is cleared. The bench then checks which words landed. A design that counted one cycle too few or too many would store a shifted block. Disabling the generator while a block is ready must drop the flag and freeze the words; a design that only stopped new fills would keep ready high. Alarms are driven twice on one oscillator, a third time on the now-disabled oscillator, and then on a second oscillator. This exposes a design that stops on the first alarm, reacts to disabled oscillators, or compares the stopped count against the threshold with the wrong inequality. A failure pulse in the same cycle as its clear shows whether the set or the clear wins.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam logic [7:0] OFF_DATA0 = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_CTRL  = 8'h14;
  localparam logic [7:0] OFF_CFG   = 8'h18;
  localparam logic [7:0] OFF_THR   = 8'h1C;
  localparam logic [7:0] OFF_OSCEN = 8'h20;
  localparam logic [7:0] OFF_TUNE  = 8'h24;
  localparam logic [7:0] OFF_AMASK = 8'h28;
  localparam logic [7:0] OFF_ASTOP = 8'h2C;
  localparam logic [7:0] OFF_OPT   = 8'h78;
  localparam logic [7:0] OFF_REV   = 8'h7C;

  localparam int CT_ENABLE = 10;
  localparam int CT_TEST   = 8;

  localparam logic [31:0] CTRL_KEEP = 32'h0000_05FF;
  localparam logic [31:0] CFG_KEEP  = 32'hFFFF_00FF;
endpackage

// File: rtl/trng_word_collect.sv
module trng_word_collect #(
  parameter int WORDS = 4,
  parameter int W     = 32,
  parameter int WAITW = 8,
  parameter int IDXW  = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  ack,
  input  logic [WAITW-1:0]      min_wait,
  input  logic                  src_valid,
  input  logic [W-1:0]          src_word,
  input  logic                  test_we,
  input  logic [IDXW-1:0]       test_idx,
  input  logic [W-1:0]          test_data,
  output logic                  ready,
  output logic [WORDS-1:0][W-1:0] words
);
  localparam logic [IDXW-1:0] LAST = IDXW'(WORDS - 1);

  logic                    rdy_q, rdy_d;
  logic [IDXW-1:0]         idx_q, idx_d;
  logic [WAITW-1:0]        wt_q, wt_d;
  logic [WORDS-1:0][W-1:0] wd_q, wd_d;

  always_comb begin
    rdy_d = rdy_q;
    idx_d = idx_q;
    wt_d  = wt_q;
    wd_d  = wd_q;
    if (!enable) begin
      rdy_d = 1'b0;
      idx_d = '0;
      wt_d  = '0;
    end else if (rdy_q) begin
      if (ack) begin
        rdy_d = 1'b0;
        idx_d = '0;
        wt_d  = min_wait;
      end
    end else if (wt_q != '0) begin
      wt_d = wt_q - 1'b1;
    end else if (src_valid) begin
      wd_d[idx_q] = src_word;
      if (idx_q == LAST) begin
        idx_d = '0;
        rdy_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
    if (test_we) wd_d[test_idx] = test_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      idx_q <= '0;
      wt_q  <= '0;
      wd_q  <= '0;
    end else begin
      rdy_q <= rdy_d;
      idx_q <= idx_d;
      wt_q  <= wt_d;
      wd_q  <= wd_d;
    end
  end

  assign ready = rdy_q;
  assign words = wd_q;
endmodule

// File: rtl/trng_osc_guard.sv
module trng_osc_guard #(
  parameter int NOSC = 8,
  parameter int THRW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOSC-1:0] alarm_hit,
  input  logic [THRW-1:0] threshold,
  input  logic            en_we,
  input  logic            mask_we,
  input  logic            stop_we,
  input  logic [NOSC-1:0] wdata,
  output logic [NOSC-1:0] osc_en,
  output logic [NOSC-1:0] amask,
  output logic [NOSC-1:0] astop,
  output logic            shut_evt
);
  localparam int CNTW = $clog2(NOSC + 1);

  logic [NOSC-1:0] en_q, en_d, mk_q, mk_d, st_q, st_d;
  logic [CNTW-1:0] stopped;
  logic            new_stop;

  always_comb begin
    en_d = en_q;
    mk_d = mk_q;
    st_d = st_q;
    for (int i = 0; i < NOSC; i++) begin
      if (alarm_hit[i] && en_q[i]) begin
        if (mk_q[i]) begin
          en_d[i] = 1'b0;
          st_d[i] = 1'b1;
        end else begin
          mk_d[i] = 1'b1;
        end
      end
    end
    new_stop = |(st_d & ~st_q);
    stopped  = '0;
    for (int i = 0; i < NOSC; i++) stopped = stopped + CNTW'(st_d[i]);
    shut_evt = new_stop && (32'(stopped) > 32'(threshold));
    if (en_we)   en_d = wdata;
    if (mask_we) mk_d = wdata;
    if (stop_we) st_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      mk_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      mk_q <= mk_d;
      st_q <= st_d;
    end
  end

  assign osc_en = en_q;
  assign amask  = mk_q;
  assign astop  = st_q;
endmodule

// File: rtl/trng_alarm_ctrl.sv
module trng_alarm_ctrl
  import trng_pkg::*;
#(
  parameter int NUM_OSC   = 8,
  parameter int WORDS     = 4,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1,
  parameter int REV_PATCH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               src_valid,
  input  logic [31:0]        src_word,
  input  logic [5:0]         hlt_fail,
  input  logic [NUM_OSC-1:0] alarm_hit,
  output logic [NUM_OSC-1:0] osc_en,
  output logic [31:0]        osc_tune,
  output logic               gen_on,
  output logic               irq
);
  localparam int IDXW = $clog2(WORDS);
  localparam logic [7:0] DATA_END = 8'(WORDS * 4);
  localparam logic [31:0] OPT_WORD = {16'd0, 8'(NUM_OSC), 8'(WORDS)};
  localparam logic [31:0] REV_WORD = {4'd0, 4'(REV_MAJOR), 4'(REV_MINOR), 4'(REV_PATCH), 16'd0};

  logic [31:0] ctrl_q, ctrl_d, cfg_q, cfg_d, tune_q, tune_d;
  logic [7:0]  thr_q, thr_d;
  logic [7:1]  st_q, st_d;

  logic wr_stat, wr_ctrl, wr_cfg, wr_thr, wr_tune, wr_en, wr_mask, wr_stop;
  logic in_data, test_we, rdy, shut_evt;
  logic [WORDS-1:0][31:0] words;
  logic [NUM_OSC-1:0] amask, astop;

  assign wr_stat = bus_we && (bus_addr == OFF_STAT);
  assign wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
  assign wr_cfg  = bus_we && (bus_addr == OFF_CFG);
  assign wr_thr  = bus_we && (bus_addr == OFF_THR);
  assign wr_tune = bus_we && (bus_addr == OFF_TUNE);
  assign wr_en   = bus_we && (bus_addr == OFF_OSCEN);
  assign wr_mask = bus_we && (bus_addr == OFF_AMASK);
  assign wr_stop = bus_we && (bus_addr == OFF_ASTOP);
  assign in_data = (bus_addr >= OFF_DATA0) && (bus_addr < DATA_END) && (bus_addr[1:0] == 2'b00);
  assign test_we = bus_we && in_data && ctrl_q[CT_TEST];

  trng_word_collect #(.WORDS(WORDS), .W(32), .WAITW(8), .IDXW(IDXW)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (ctrl_q[CT_ENABLE]),
    .ack       (wr_stat && bus_wdata[0]),
    .min_wait  (cfg_q[7:0]),
    .src_valid (src_valid),
    .src_word  (src_word),
    .test_we   (test_we),
    .test_idx  (bus_addr[IDXW+1:2]),
    .test_data (bus_wdata),
    .ready     (rdy),
    .words     (words)
  );

  trng_osc_guard #(.NOSC(NUM_OSC), .THRW(8)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .alarm_hit (alarm_hit),
    .threshold (thr_q),
    .en_we     (wr_en),
    .mask_we   (wr_mask),
    .stop_we   (wr_stop),
    .wdata     (bus_wdata[NUM_OSC-1:0]),
    .osc_en    (osc_en),
    .amask     (amask),
    .astop     (astop),
    .shut_evt  (shut_evt)
  );

  always_comb begin
    ctrl_d = wr_ctrl ? (bus_wdata & CTRL_KEEP) : ctrl_q;
    cfg_d  = wr_cfg  ? (bus_wdata & CFG_KEEP)  : cfg_q;
    thr_d  = wr_thr  ? bus_wdata[7:0]          : thr_q;
    tune_d = wr_tune ? bus_wdata               : tune_q;
    st_d   = wr_stat ? (st_q & ~bus_wdata[7:1]) : st_q;
    st_d[7:2] = st_d[7:2] | hlt_fail;
    st_d[1]   = st_d[1] | shut_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      thr_q  <= '0;
      tune_q <= '0;
      st_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cfg_q  <= cfg_d;
      thr_q  <= thr_d;
      tune_q <= tune_d;
      st_q   <= st_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_data) begin
      bus_rdata = words[bus_addr[IDXW+1:2]];
    end else begin
      case (bus_addr)
        OFF_STAT:  bus_rdata = {24'd0, st_q, rdy};
        OFF_CTRL:  bus_rdata = ctrl_q;
        OFF_CFG:   bus_rdata = cfg_q;
        OFF_THR:   bus_rdata = {24'd0, thr_q};
        OFF_OSCEN: bus_rdata = 32'(osc_en);
        OFF_TUNE:  bus_rdata = tune_q;
        OFF_AMASK: bus_rdata = 32'(amask);
        OFF_ASTOP: bus_rdata = 32'(astop);
        OFF_OPT:   bus_rdata = OPT_WORD;
        OFF_REV:   bus_rdata = REV_WORD;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign osc_tune = tune_q;
  assign gen_on   = ctrl_q[CT_ENABLE];
  assign irq      = |({st_q, rdy} & ctrl_q[7:0]);
endmodule

// File: rtl/trng_alarm_ctrl_chk.sv
module trng_alarm_ctrl_chk #(
  parameter int NUM_OSC = 8,
  parameter int WORDS   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [7:0]         bus_addr,
  input logic               gen_on,
  input logic               test_mode,
  input logic               ready,
  input logic               irq,
  input logic [7:0]         irq_en,
  input logic [WORDS*32-1:0] words,
  input logic [NUM_OSC-1:0] alarm_hit,
  input logic [NUM_OSC-1:0] osc_en,
  input logic [NUM_OSC-1:0] stop
);
  // R5: ready drops in the cycle after the generator is seen off
  a_r5_ready_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_on |=> !ready);

  // R5: words frozen while off and outside test mode
  a_r5_words_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_on && !test_mode) |=> $stable(words));

  // R7: no interrupt when every enable is clear
  a_r7_irq_silent_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 8'h00) |-> !irq);

  // R9: a new stop bit needs an alarm or a bus write in the cycle before
  a_r9_stop_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stop & ~$past(stop))) |-> $past((|alarm_hit) || (bus_we && bus_addr == 8'h2C)));

  // R9: an oscillator drops only through a stop or a bus write
  a_r9_osc_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(osc_en) & ~osc_en)) |-> ($past(bus_we && bus_addr == 8'h20) || (|(stop & ~$past(stop)))));
endmodule

bind trng_alarm_ctrl trng_alarm_ctrl_chk #(.NUM_OSC(NUM_OSC), .WORDS(WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .gen_on    (gen_on),
  .test_mode (ctrl_q[8]),
  .ready     (rdy),
  .irq       (irq),
  .irq_en    (ctrl_q[7:0]),
  .words     (words),
  .alarm_hit (alarm_hit),
  .osc_en    (osc_en),
  .stop      (astop)
);

// File: tb/trng_alarm_ctrl_tb.sv
module trng_alarm_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NOSC = 8;
  localparam int NVEC = 11;
  // {addr, write data, expected read}
  localparam logic [71:0] VECS [NVEC] = '{
    {8'h14, 32'hFFFF_FFFF, 32'h0000_05FF},
    {8'h14, 32'h0000_0000, 32'h0000_0000},
    {8'h18, 32'hFFFF_FFFF, 32'hFFFF_00FF},
    {8'h18, 32'h0000_0000, 32'h0000_0000},
    {8'h1C, 32'h0000_1234, 32'h0000_0034},
    {8'h24, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {8'h20, 32'hFFFF_FFFF, 32'h0000_00FF},
    {8'h28, 32'h0000_000F, 32'h0000_000F},
    {8'h2C, 32'h0000_0003, 32'h0000_0003},
    {8'h28, 32'h0000_0000, 32'h0000_0000},
    {8'h2C, 32'h0000_0000, 32'h0000_0000}
  };

  logic clk, rst_n, bus_we, src_valid, gen_on, irq;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, src_word, osc_tune;
  logic [5:0] hlt_fail;
  logic [NOSC-1:0] alarm_hit, osc_en;
  int checks = 0;
  int errors = 0;

  trng_alarm_ctrl #(.NUM_OSC(NOSC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_valid(src_valid),
    .src_word(src_word), .hlt_fail(hlt_fail), .alarm_hit(alarm_hit),
    .osc_en(osc_en), .osc_tune(osc_tune), .gen_on(gen_on), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic alarm(input logic [NOSC-1:0] m);
    @(negedge clk); alarm_hit = m;
    @(negedge clk); alarm_hit = '0;
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    src_valid = 1'b0; src_word = '0; hlt_fail = '0; alarm_hit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_reg("R1 status", 8'h10, 32'h0);
    chk_reg("R1 ctrl", 8'h14, 32'h0);
    chk_reg("R1 data0", 8'h00, 32'h0);
    check("R1 osc_en", 32'(osc_en), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 register table
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i][71:64], VECS[i][63:32]);
      chk_reg("R2 table", VECS[i][71:64], VECS[i][31:0]);
    end
    check("R2 osc_tune", osc_tune, 32'hA5A5_5A5A);
    check("R2 osc_en port", 32'(osc_en), 32'h0000_00FF);
    chk_reg("R2 revision", 8'h7C, 32'h0213_0000);
    chk_reg("R2 options", 8'h78, 32'h0000_0804);

    // R3 fill one block, fifth word ignored
    wr(8'h14, 32'h400);
    check("R3 gen_on", 32'(gen_on), 32'h1);
    for (int k = 0; k < 5; k++) begin
      src_valid = 1'b1; src_word = 32'hC0DE_0000 + k;
      @(negedge clk);
    end
    src_valid = 1'b0;
    chk_reg("R3 ready", 8'h10, 32'h1);
    for (int i = 0; i < 4; i++) chk_reg("R3 word", 8'(4 * i), 32'hC0DE_0000 + i);

    // R7 ready interrupt
    wr(8'h14, 32'h401);
    check("R7 ready irq", 32'(irq), 32'h1);
    wr(8'h14, 32'h400);
    check("R7 irq off", 32'(irq), 32'h0);

    // R4 acknowledge with refill delay of 3
    wr(8'h18, 32'h3);
    wr(8'h10, 32'h1);
    chk_reg("R4 ready cleared", 8'h10, 32'h0);
    for (int k = 0; k < 7; k++) begin
      src_valid = 1'b1; src_word = 32'hBEEF_0000 + k;
      @(negedge clk);
    end
    src_valid = 1'b0;
    chk_reg("R4 ready again", 8'h10, 32'h1);
    for (int i = 0; i < 4; i++) chk_reg("R4 word after delay", 8'(4 * i), 32'hBEEF_0003 + i);

    // R5 disable while ready
    wr(8'h18, 32'h0);
    wr(8'h10, 32'h1);
    for (int k = 0; k < 4; k++) begin
      src_valid = 1'b1; src_word = 32'hF00D_0000 + k;
      @(negedge clk);
    end
    src_valid = 1'b0;
    chk_reg("R5 ready before off", 8'h10, 32'h1);
    wr(8'h14, 32'h0);
    @(negedge clk);
    chk_reg("R5 ready forced low", 8'h10, 32'h0);
    for (int k = 0; k < 4; k++) begin
      src_valid = 1'b1; src_word = 32'h5555_0000 + k;
      @(negedge clk);
    end
    src_valid = 1'b0;
    chk_reg("R5 ready stays low", 8'h10, 32'h0);
    chk_reg("R5 word0 held", 8'h00, 32'hF00D_0000);
    chk_reg("R5 word3 held", 8'h0C, 32'hF00D_0003);

    // R11 test-mode writes
    wr(8'h14, 32'h100);
    wr(8'h04, 32'hDEAD_BEEF);
    chk_reg("R11 test write", 8'h04, 32'hDEAD_BEEF);
    wr(8'h14, 32'h0);
    wr(8'h08, 32'h1111_1111);
    chk_reg("R11 write ignored", 8'h08, 32'hF00D_0002);

    // R6 sticky failures and W1C
    @(negedge clk); hlt_fail = 6'b000001;
    @(negedge clk); hlt_fail = 6'b100000;
    @(negedge clk); hlt_fail = '0;
    chk_reg("R6 sticky", 8'h10, 32'h84);
    wr(8'h10, 32'h04);
    chk_reg("R6 selective clear", 8'h10, 32'h80);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h80; hlt_fail = 6'b100000;
    @(negedge clk);
    bus_we = 1'b0; hlt_fail = '0;
    chk_reg("R6 set wins", 8'h10, 32'h80);
    wr(8'h14, 32'h80);
    check("R7 failure irq", 32'(irq), 32'h1);
    wr(8'h14, 32'h40);
    check("R7 other enable", 32'(irq), 32'h0);
    wr(8'h10, 32'h80);
    wr(8'h14, 32'h0);
    chk_reg("R6 cleared", 8'h10, 32'h0);

    // R8 R9 R10 alarms, threshold 1
    wr(8'h1C, 32'h1);
    alarm(8'h01);
    chk_reg("R8 mask set", 8'h28, 32'h01);
    chk_reg("R8 still enabled", 8'h20, 32'hFF);
    chk_reg("R8 no stop", 8'h2C, 32'h0);
    alarm(8'h01);
    chk_reg("R9 osc off", 8'h20, 32'hFE);
    chk_reg("R9 stop set", 8'h2C, 32'h01);
    chk_reg("R10 not over", 8'h10, 32'h0);
    alarm(8'h01);
    chk_reg("R9 disabled ignored", 8'h2C, 32'h01);
    chk_reg("R9 disabled mask", 8'h28, 32'h01);
    alarm(8'h02);
    alarm(8'h02);
    chk_reg("R9 second stop", 8'h2C, 32'h03);
    check("R9 osc_en port", 32'(osc_en), 32'hFC);
    chk_reg("R10 overflow", 8'h10, 32'h02);
    wr(8'h14, 32'h2);
    check("R7 shutdown irq", 32'(irq), 32'h1);

    // R2 recovery writes
    wr(8'h24, 32'h3);
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    chk_reg("R2 stop cleared", 8'h2C, 32'h0);
    check("R2 osc restored", 32'(osc_en), 32'hFF);

    report();
    $finish;
  end
endmodule